// File: doc/BRIEF.md
# Power-On Initialization Sequencer

This block walks a processor-style core from the release of system reset to the start of instruction execution. After reset it first lets the clock generator ramp. It then runs a two-phase handshake on a forward-reset line that the system drives. The first phase brackets built-in self-test and the serial configuration load. The second phase gates the start of the external clocks. A fixed settle count then runs before the core is allowed to execute.

All outputs are decoded from a single state register, and a 4-bit status output shows that state. The single-cycle start pulses go to the self-test engine and to the serial ROM loader. Their done inputs close each phase. If the system fails to hold the forward-reset line high when the handshake phase begins, the sequencer parks in a fault state with a sticky error flag.

Top module: `por_init_seq`

## Requirements
- R1: While rst_ni is low, and for two clock edges after it rises, status_o is 0 and every output is inactive: pll_ramp_o, bist_start_o, load_start_o, ext_clk_en_o, run_en_o and err_o are 0, and srom_oe_no is 1. Driving rst_ni low at any time forces this state without waiting for a clock edge.
- R2: After reset release the sequencer enters status 1 with pll_ramp_o high. It leaves status 1 after the first cycle in which pll_lock_i is high, or after PLL_TIMEOUT cycles (64 by default) if lock never comes.
- R3: When the ramp ends, fwd_rst_i high moves the sequencer to status 2. fwd_rst_i low moves it to status 15 with err_o high, and it stays in status 15 until reset.
- R4: In status 2 the sequencer waits for fwd_rst_i low. It then spends exactly one cycle in status 3 with bist_start_o high.
- R5: In status 4 it waits for bist_done_i. It then spends exactly one cycle in status 5 with load_start_o high. A done input that arrives in any other state has no effect, and load_start_o never precedes a bist_done_i taken in status 4.
- R6: In status 6 it waits for load_done_i and then enters status 7. In status 7 it waits for fwd_rst_i low before the external clocks start.
- R7: ext_clk_en_o is high in status 8 and status 9. run_en_o rises, together with the move to status 9, exactly SETTLE_CYCLES (264) cycles after ext_clk_en_o rises.
- R8: srom_oe_no is low in exactly statuses 2 through 6. It is never low while ext_clk_en_o is high.
- R9: err_o rises only on the fault of R3 and, once high, stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low system reset, asynchronous assert |
| pll_lock_i | input | 1 | Clock generator lock indication |
| fwd_rst_i | input | 1 | Forward-reset handshake line from the system |
| bist_done_i | input | 1 | Self-test engine completion |
| load_done_i | input | 1 | Serial ROM load completion |
| pll_ramp_o | output | 1 | Clock generator ramp enable |
| srom_oe_no | output | 1 | Serial ROM output enable, active low |
| bist_start_o | output | 1 | One-cycle self-test start pulse |
| load_start_o | output | 1 | One-cycle serial load start pulse |
| ext_clk_en_o | output | 1 | External clock enable |
| run_en_o | output | 1 | Instruction execution enable |
| err_o | output | 1 | Sticky handshake protocol error |
| status_o | output | 4 | Current sequencer state code |

## Verification
Every output is decoded from the state register, so a wrong state shows on status_o at the very next clock edge. In most cases at least one control output changes in that same cycle. A wrong value in the shared cycle counter is less direct. It shows up only as a ramp or settle phase of the wrong length, which is visible when pll_ramp_o falls or when run_en_o rises. The bench therefore measures both phase lengths at the ports, and it checks the state on every cycle against an independent model.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE_RST  = 4'd0,
    ST_PLL_RAMP  = 4'd1,
    ST_FWD_HOLD  = 4'd2,
    ST_BIST_GO   = 4'd3,
    ST_BIST_WAIT = 4'd4,
    ST_LOAD_GO   = 4'd5,
    ST_LOAD_WAIT = 4'd6,
    ST_CLK_HOLD  = 4'd7,
    ST_SETTLE    = 4'd8,
    ST_RUN       = 4'd9,
    ST_FAULT     = 4'd15
  } seq_state_e;

endpackage

// File: rtl/por_rst_sync.sv
module por_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/por_phase_cnt.sv
module por_phase_cnt #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_d, cnt_q;
  logic         cnt_we;

  always_comb begin
    cnt_we = clr_i | en_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
  import por_seq_pkg::*;
#(
  parameter int PLL_TIMEOUT   = 64,
  parameter int SETTLE_CYCLES = 264,
  parameter int CW            = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pll_lock_i,
  input  logic          fwd_rst_i,
  input  logic          bist_done_i,
  input  logic          load_done_i,
  input  logic [CW-1:0] cnt_i,
  output logic          cnt_clr_o,
  output logic          cnt_en_o,
  output logic          pll_ramp_o,
  output logic          srom_oe_no,
  output logic          bist_start_o,
  output logic          load_start_o,
  output logic          ext_clk_en_o,
  output logic          run_en_o,
  output logic          err_o,
  output logic [3:0]    status_o
);

  localparam logic [CW-1:0] PLL_LAST    = CW'(PLL_TIMEOUT - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE_RST:  state_d = ST_PLL_RAMP;
      ST_PLL_RAMP: begin
        if (pll_lock_i || (cnt_i == PLL_LAST)) begin
          state_d = fwd_rst_i ? ST_FWD_HOLD : ST_FAULT;
        end
      end
      ST_FWD_HOLD:  if (!fwd_rst_i)  state_d = ST_BIST_GO;
      ST_BIST_GO:   state_d = ST_BIST_WAIT;
      ST_BIST_WAIT: if (bist_done_i) state_d = ST_LOAD_GO;
      ST_LOAD_GO:   state_d = ST_LOAD_WAIT;
      ST_LOAD_WAIT: if (load_done_i) state_d = ST_CLK_HOLD;
      ST_CLK_HOLD:  if (!fwd_rst_i)  state_d = ST_SETTLE;
      ST_SETTLE:    if (cnt_i == SETTLE_LAST) state_d = ST_RUN;
      ST_RUN:       state_d = ST_RUN;
      ST_FAULT:     state_d = ST_FAULT;
      default:      state_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE_RST;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    cnt_clr_o    = (state_d != state_q);
    cnt_en_o     = (state_q == ST_PLL_RAMP) || (state_q == ST_SETTLE);
    pll_ramp_o   = (state_q == ST_PLL_RAMP);
    srom_oe_no   = !((state_q == ST_FWD_HOLD)  || (state_q == ST_BIST_GO) ||
                     (state_q == ST_BIST_WAIT) || (state_q == ST_LOAD_GO) ||
                     (state_q == ST_LOAD_WAIT));
    bist_start_o = (state_q == ST_BIST_GO);
    load_start_o = (state_q == ST_LOAD_GO);
    ext_clk_en_o = (state_q == ST_SETTLE) || (state_q == ST_RUN);
    run_en_o     = (state_q == ST_RUN);
    err_o        = (state_q == ST_FAULT);
    status_o     = state_q;
  end

  // R4
  bist_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bist_start_o |=> !bist_start_o);

  // R5
  load_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_start_o |=> !load_start_o);

  // R5
  load_after_bist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_start_o) |-> $past(bist_done_i));

  // R7
  run_after_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_en_o) |-> $past(ext_clk_en_o));

  // R7
  settle_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE) |-> (cnt_i <= SETTLE_LAST));

  // R2
  ramp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_ramp_o |-> (cnt_i <= PLL_LAST));

  // R8
  oe_clk_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!srom_oe_no && ext_clk_en_o));

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

endmodule

// File: rtl/por_init_seq.sv
module por_init_seq #(
  parameter int PLL_TIMEOUT   = 64,
  parameter int SETTLE_CYCLES = 264,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pll_lock_i,
  input  logic       fwd_rst_i,
  input  logic       bist_done_i,
  input  logic       load_done_i,
  output logic       pll_ramp_o,
  output logic       srom_oe_no,
  output logic       bist_start_o,
  output logic       load_start_o,
  output logic       ext_clk_en_o,
  output logic       run_en_o,
  output logic       err_o,
  output logic [3:0] status_o
);

  localparam int MAX_PHASE = (PLL_TIMEOUT > SETTLE_CYCLES) ? PLL_TIMEOUT : SETTLE_CYCLES;
  localparam int CW        = $clog2(MAX_PHASE + 1);

  logic          rst_sync_n;
  logic          cnt_clr, cnt_en;
  logic [CW-1:0] cnt;

  por_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  por_phase_cnt #(.W(CW)) u_phase_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .cnt_o  (cnt)
  );

  por_seq_fsm #(
    .PLL_TIMEOUT   (PLL_TIMEOUT),
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .CW            (CW)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .pll_lock_i   (pll_lock_i),
    .fwd_rst_i    (fwd_rst_i),
    .bist_done_i  (bist_done_i),
    .load_done_i  (load_done_i),
    .cnt_i        (cnt),
    .cnt_clr_o    (cnt_clr),
    .cnt_en_o     (cnt_en),
    .pll_ramp_o   (pll_ramp_o),
    .srom_oe_no   (srom_oe_no),
    .bist_start_o (bist_start_o),
    .load_start_o (load_start_o),
    .ext_clk_en_o (ext_clk_en_o),
    .run_en_o     (run_en_o),
    .err_o        (err_o),
    .status_o     (status_o)
  );

endmodule

// File: tb/por_init_seq_tb_top.sv
`timescale 1ns/1ps
module por_init_seq_tb_top;

  localparam int TMO    = 64;
  localparam int SETTLE = 264;

  logic clk, rst_n, lock, fwd, bdone, ldone;
  logic pll, oe_n, bst, lst, ext, run, err;
  logic [3:0] status;

  int tests, fails;

  por_init_seq #(.PLL_TIMEOUT(TMO), .SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pll_lock_i(lock), .fwd_rst_i(fwd),
    .bist_done_i(bdone), .load_done_i(ldone), .pll_ramp_o(pll), .srom_oe_no(oe_n),
    .bist_start_o(bst), .load_start_o(lst), .ext_clk_en_o(ext), .run_en_o(run),
    .err_o(err), .status_o(status)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // independent reference model built from the requirements
  logic [1:0] m_sync;
  logic [3:0] m_st;
  int         m_cnt;

  function automatic logic [3:0] m_next(logic [3:0] s, int c, logic lk, logic fw,
                                        logic bd, logic ld);
    case (s)
      4'd0:  return 4'd1;
      4'd1:  return (lk || c == TMO-1) ? (fw ? 4'd2 : 4'd15) : 4'd1;
      4'd2:  return fw ? 4'd2 : 4'd3;
      4'd3:  return 4'd4;
      4'd4:  return bd ? 4'd5 : 4'd4;
      4'd5:  return 4'd6;
      4'd6:  return ld ? 4'd7 : 4'd6;
      4'd7:  return fw ? 4'd7 : 4'd8;
      4'd8:  return (c == SETTLE-1) ? 4'd9 : 4'd8;
      4'd9:  return 4'd9;
      default: return 4'd15;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync <= 2'b00; m_st <= 4'd0; m_cnt <= 0;
    end else begin
      m_sync <= {m_sync[0], 1'b1};
      if (!m_sync[1]) begin
        m_st <= 4'd0; m_cnt <= 0;
      end else begin
        logic [3:0] nx;
        nx = m_next(m_st, m_cnt, lock, fwd, bdone, ldone);
        if (nx != m_st) m_cnt <= 0;
        else if (m_st == 4'd1 || m_st == 4'd8) m_cnt <= m_cnt + 1;
        m_st <= nx;
      end
    end
  end

  function automatic logic [10:0] exp_vec(logic [3:0] s);
    logic [6:0] o;
    o[6] = (s == 4'd1);
    o[5] = !(s >= 4'd2 && s <= 4'd6);
    o[4] = (s == 4'd3);
    o[3] = (s == 4'd5);
    o[2] = (s == 4'd8 || s == 4'd9);
    o[1] = (s == 4'd9);
    o[0] = (s == 4'd15);
    return {s, o};
  endfunction

  function automatic string tag_of(logic [3:0] s);
    case (s)
      4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";
      4'd3: return "R4";  4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R6";  4'd8, 4'd9: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // port monitors
  int  ext_cnt, ramp_cnt, last_ramp;
  bit  run_seen, bist_taken, prev_pll;
  logic [10:0] act_v;

  task automatic clear_mon();
    ext_cnt = 0; ramp_cnt = 0; last_ramp = -1; run_seen = 0; bist_taken = 0; prev_pll = 0;
  endtask

  task automatic compare_all();
    act_v = {status, pll, oe_n, bst, lst, ext, run, err};
    check(tag_of(m_st), 32'(act_v), 32'(exp_vec(m_st)), "outputs vs model");
    if (oe_n !== act_v[5]) check("R8", 0, 1, "oe");
    check("R8", 32'(!oe_n && ext), 0, "oe_n low with ext clk");
    if (err && !(status == 4'd15)) check("R9", 0, 1, "err outside fault");
    if (lst && !bist_taken) check("R5", 1, 0, "load start before bist done");
    if (pll) ramp_cnt++;
    if (prev_pll && !pll) last_ramp = ramp_cnt;
    prev_pll = pll;
    if (ext && !run) ext_cnt++;
    if (run && !run_seen) begin
      run_seen = 1;
      check("R7", 32'(ext_cnt), 32'(SETTLE), "settle length");
    end
  endtask

  bit fault_mode, never_lock;

  task automatic drive();
    lock = never_lock ? 1'b0 : ($urandom % 8 == 0);
    case (status)
      4'd1:    fwd = !fault_mode;
      4'd2:    fwd = ($urandom % 4 != 0);
      4'd7:    fwd = ($urandom % 3 != 0);
      default: fwd = $urandom % 2;
    endcase
    bdone = (status == 4'd4) ? ($urandom % 5 == 0) : ($urandom % 2);
    ldone = (status == 4'd6) ? ($urandom % 5 == 0) : ($urandom % 2);
    if (status == 4'd4 && bdone) bist_taken = 1;
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    drive();
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1", 32'({status, pll, oe_n, bst, lst, ext, run, err}),
          32'({4'd0, 7'b0100000}), "async reset outputs");
    repeat (n) step();
    clear_mon();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_until_done(int limit);
    for (int i = 0; i < limit; i++) begin
      step();
      if (status == 4'd9 || status == 4'd15) begin
        repeat (12) step();
        break;
      end
    end
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    tests = 0; fails = 0;
    rst_n = 1'b0; lock = 0; fwd = 0; bdone = 0; ldone = 0;
    fault_mode = 0; never_lock = 0;
    clear_mon();
    repeat (3) step();
    check("R1", 32'(status), 0, "status in reset");
    check("R1", 32'(oe_n), 1, "oe_n high in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // two edges after release still idle
    step(); check("R1", 32'(status), 0, "idle after 1st edge");
    step(); check("R1", 32'(status), 0, "idle after 2nd edge");
    step(); check("R2", 32'(pll), 1, "ramp after sync");
    run_until_done(2000);
    check("R7", 32'(run), 1, "run reached");
    // more random full runs
    for (int k = 0; k < 4; k++) begin
      do_reset(2);
      run_until_done(2000);
      check("R7", 32'(run), 1, "run reached random");
      check("R9", 32'(err), 0, "no error on clean run");
    end
    // lock never arrives: ramp must time out
    never_lock = 1;
    do_reset(3);
    run_until_done(2000);
    check("R2", 32'(last_ramp), 32'(TMO), "ramp timeout length");
    never_lock = 0;
    // forward reset low at handshake entry: fault
    fault_mode = 1;
    do_reset(2);
    run_until_done(2000);
    check("R3", 32'(status), 15, "fault state");
    check("R9", 32'(err), 1, "err set");
    repeat (20) step();
    check("R9", 32'(err), 1, "err sticky");
    check("R3", 32'(ext), 0, "no clocks after fault");
    fault_mode = 0;
    // reset in the middle of sequences
    for (int k = 0; k < 3; k++) begin
      do_reset(2);
      repeat (20 + ($urandom % 200)) step();
      do_reset(4);
      run_until_done(2000);
      check("R1", 32'(run), 1, "recovery after mid reset");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule